// File: doc/BRIEF.md
# Servo Pulse Width Discriminator

This block turns the high time of a hobby radio-control servo pulse into a single logic bit. The pulse line comes in asynchronously. It passes through a two-stage synchroniser, and edges are taken from the synchronised copy. A width counter runs from a free-running reference clock. A rising edge clears the counter and it then counts every clock cycle for which the line stays high. When the line falls, the final count is compared against two thresholds. The result goes into an output register, which holds its value until the next accepted pulse.

The thresholds are hysteretic. The output goes high only when the count is above the upper limit. It goes low only when the count is below the lower limit. A count between the two limits leaves the output as it was. A pulse much shorter or much longer than the nominal servo range is discarded without effect. The counter stops at a ceiling instead of wrapping, so a very long pulse can never alias to a short count. Each accepted pulse raises a one-cycle strobe.

The width of a pulse is the number of rising clock edges at which the synchronised line is high. `CYC_PER_MS` sets the clock count per millisecond (N). Defaults:

| Setting | Value |
|---|---|
| Upper limit | 1.6N |
| Lower limit | 1.4N |
| Shortest accepted width | N/2 |
| Longest accepted width | 3N |

Top module: `servo_bit_decoder`

## Requirements
- R1: A pulse of N clocks (about 1 ms) makes `bit_out` 0 once it has been accepted.
- R2: A pulse of 2N clocks (about 2 ms) makes `bit_out` 1 once it has been accepted.
- R3: An accepted width strictly above the upper limit sets `bit_out` to 1. A width strictly below the lower limit clears it to 0. A width from the lower limit to the upper limit, both inclusive, leaves `bit_out` unchanged.
- R4: `bit_out` changes only in the cycle where `bit_valid` is 1, and holds its value between pulses.
- R5: The decision appears at the third rising clock edge after the pulse line falls, counting the first edge that samples it low, because of the synchroniser and edge detector.
- R6: A pulse with width below the shortest accepted width (N/2) raises no strobe and leaves `bit_out` unchanged. A width of exactly N/2 is accepted.
- R7: A pulse with width above the longest accepted width (3N) raises no strobe and leaves `bit_out` unchanged. A width of exactly 3N is accepted.
- R8: The width counter saturates one above the longest accepted width. A pulse whose width modulo the counter range would fall inside the accepted band is still rejected.
- R9: `bit_valid` is 1 for exactly one cycle per accepted pulse, and is 1 for in-band widths that hold the output.
- R10: While `rst_n` is low, and after it is released, `bit_out` and `bit_valid` read 0 until a pulse is accepted. Reset is asserted asynchronously and released synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the width counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous servo pulse line |
| bit_out | output | 1 | Latched one-bit decision |
| bit_valid | output | 1 | One-cycle strobe when a pulse is accepted |

## Verification
The bench builds the block with `CYC_PER_MS` = 100. This gives an upper limit of 160, a lower limit of 140 and an accepted band of 50 to 300. The counter is 9 bits wide and saturates at 301. Every limit and every value one step beyond it can be reached within a few hundred cycles. A 712-cycle pulse wraps a 9-bit counter to 200, so it shows whether the counter saturates. Pulses of 1 ms and 2 ms take only 100 and 200 cycles.

// File: rtl/svd_pkg.sv
package svd_pkg;
  // Scale a base count by a percentage, truncating.
  function automatic int unsigned pct_of(input int unsigned base, input int unsigned pct);
    return (base * pct) / 100;
  endfunction
endpackage

// File: rtl/svd_in_sync.sv
module svd_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;
  logic meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = async_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
  assign fall_o  = ~sync_q & prev_q;

  // R5: a fall must follow a cycle in which the synchronised level was high
  a_r5_fall_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> $past(level_o));
endmodule

// File: rtl/svd_width_cnt.sv
module svd_width_cnt #(
  parameter int unsigned CW  = 9,
  parameter int unsigned SAT = 301
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          level_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = rise_i | (level_i && (cnt_q != CW'(SAT)));
    if (rise_i)      cnt_d = CW'(1);
    else if (cnt_en) cnt_d = cnt_q + CW'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SAT));
  a_r8_restart_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/svd_decide.sv
module svd_decide #(
  parameter int unsigned CW     = 9,
  parameter int unsigned LO_LIM = 140,
  parameter int unsigned HI_LIM = 160,
  parameter int unsigned MIN_W  = 50,
  parameter int unsigned MAX_W  = 300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_i,
  input  logic [CW-1:0] cnt_i,
  output logic          bit_o,
  output logic          valid_o
);
  logic bit_q, bit_d, valid_q, valid_d;
  logic in_range, go_hi, go_lo;

  always_comb begin
    in_range = (cnt_i >= CW'(MIN_W)) && (cnt_i <= CW'(MAX_W));
    go_hi    = cnt_i > CW'(HI_LIM);
    go_lo    = cnt_i < CW'(LO_LIM);
    valid_d  = fall_i & in_range;
    bit_d    = bit_q;
    if (valid_d) begin
      if (go_hi)      bit_d = 1'b1;
      else if (go_lo) bit_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (valid_d) bit_q <= bit_d;
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  a_r4_change_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q != $past(bit_q)) |-> valid_q);
  a_r6_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (($past(cnt_i) >= CW'(MIN_W)) && ($past(cnt_i) <= CW'(MAX_W))));
  a_r3_rise_above_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_q) |-> ($past(cnt_i) > CW'(HI_LIM)));
  a_r3_fall_below_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_q) |-> ($past(cnt_i) < CW'(LO_LIM)));
endmodule

// File: rtl/servo_bit_decoder.sv
module servo_bit_decoder #(
  parameter int unsigned CYC_PER_MS = 50000,
  parameter int unsigned HI_PCT     = 160,
  parameter int unsigned LO_PCT     = 140,
  parameter int unsigned MIN_PCT    = 50,
  parameter int unsigned MAX_PCT    = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic bit_out,
  output logic bit_valid
);
  import svd_pkg::*;

  localparam int unsigned HI_LIM = pct_of(CYC_PER_MS, HI_PCT);
  localparam int unsigned LO_LIM = pct_of(CYC_PER_MS, LO_PCT);
  localparam int unsigned MIN_W  = pct_of(CYC_PER_MS, MIN_PCT);
  localparam int unsigned MAX_W  = pct_of(CYC_PER_MS, MAX_PCT);
  localparam int unsigned SAT    = MAX_W + 1;
  localparam int unsigned CW     = $clog2(SAT + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  logic          lvl, rise, fall;
  logic [CW-1:0] width;

  svd_in_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .async_i (pulse_in),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  svd_width_cnt #(.CW(CW), .SAT(SAT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .rise_i  (rise),
    .level_i (lvl),
    .cnt_o   (width)
  );

  svd_decide #(
    .CW(CW), .LO_LIM(LO_LIM), .HI_LIM(HI_LIM), .MIN_W(MIN_W), .MAX_W(MAX_W)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .fall_i  (fall),
    .cnt_i   (width),
    .bit_o   (bit_out),
    .valid_o (bit_valid)
  );

  // R10: outputs are quiet while the internal reset is held
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n_i |=> (!bit_out && !bit_valid));
endmodule

// File: tb/servo_bit_decoder_tb_top.sv
module servo_bit_decoder_tb_top;
  localparam int N = 100;

  logic clk = 1'b0;
  logic rst_n;
  logic pulse_in;
  logic bit_out, bit_valid;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  servo_bit_decoder #(.CYC_PER_MS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
    .bit_out(bit_out), .bit_valid(bit_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one pulse of width w (in clock edges), then observe for 12 cycles.
  task automatic pulse(input string req, input int w, input int exp_strobes, input int exp_bit);
    int strobes = 0;
    int first_at = -1;
    pulse_in = 1'b1;
    repeat (w) @(negedge clk);
    pulse_in = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (bit_valid) begin
        strobes++;
        if (first_at < 0) first_at = i;
      end
    end
    check({req, " strobe count"}, strobes, exp_strobes);
    check({req, " output"}, int'(bit_out), exp_bit);
    if (exp_strobes == 1) check({req, " R5 latency"}, first_at, 2);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pulse_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 bit in reset", int'(bit_out), 0);
    check("R10 strobe in reset", int'(bit_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 bit after release", int'(bit_out), 0);
  endtask

  task automatic t_nominal;
    pulse("R2 2ms", 2 * N, 1, 1);
    pulse("R1 1ms", N, 1, 0);
  endtask

  task automatic t_hysteresis;
    pulse("R3 band from low", 150, 1, 0);
    pulse("R3 at upper limit holds", 160, 1, 0);
    pulse("R3 above upper", 161, 1, 1);
    pulse("R9 band from high holds", 150, 1, 1);
    pulse("R3 at lower limit holds", 140, 1, 1);
    pulse("R3 below lower", 139, 1, 0);
    repeat (40) @(negedge clk);
    check("R4 held between pulses", int'(bit_out), 0);
  endtask

  task automatic t_limits;
    pulse("R6 short rejected", 49, 0, 0);
    pulse("R6 min accepted", 50, 1, 0);
    pulse("R2 set high", 200, 1, 1);
    pulse("R6 short keeps high", 20, 0, 1);
    pulse("R7 long rejected", 301, 0, 1);
    pulse("R1 clear low", 100, 1, 0);
    pulse("R7 max accepted", 300, 1, 1);
    pulse("R1 clear again", 100, 1, 0);
    pulse("R8 saturation no alias", 712, 0, 0);
  endtask

  initial begin
    t_reset();
    t_nominal();
    t_hysteresis();
    t_limits();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule